// File: doc/BRIEF.md
# Static Memory Strobe Generator

This block sits between an internal requester and an external bank of static memories. It serves up to four chip selects. It takes one read or write request at a time, picks the chip select from the top address bits and drives the active-low strobes that the memory devices on that select expect. When the access finishes, it returns a one-cycle done pulse that carries the read data.

Each chip select has its own configuration word, which software loads through a plain write port. The word holds three things. The first is the data width, 32 or 16 bits. The second is the strobe convention. In byte-write mode, each byte lane has its own write strobe and one output enable serves all lanes. In byte-select mode, per-lane select lines serve both reads and writes, with one shared write strobe. The third is a wait-state count. The external device can stretch any access by holding its active-low wait input low.

The request side is valid/ready. The block raises `req_ready` only while idle, so a request is taken on a cycle where both `req_valid` and `req_ready` are high, and only one access is ever outstanding. A requester facing a low `req_ready` must hold its request until it is taken. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the requester must capture `rsp_rdata` in that cycle.

Top module: `smc_strobe_gen`

## Requirements
- R1: While reset is held and right after it, every strobe output (`n_ce`, `n_we`, `n_wr`, `n_oe`) is high, `mem_doe` and `rsp_valid` are low, and `req_ready` is high.
- R2: After reset, every chip select is in 16-bit, byte-write mode with zero wait states. This includes chip select 0, so a read there returns only bits 15:0.
- R3: The chip select is `req_addr[ADDR_W-1 -: 2]`. During an access only that select's `n_ce` bit is low, and `mem_addr` equals the accepted address.
- R4: With `n_wait` held high, an access keeps its `n_ce` low for exactly 1 + N cycles, where N is the programmed wait count.
- R5: Each active cycle in which `n_wait` is sampled low adds one more cycle to the access.
- R6: A write in byte-write mode (`cfg_bsel`=0) drives `n_we[i]` low exactly for the enabled lanes (`req_be[i]`=1, lane i = data bits 8i+7:8i). It keeps `n_wr` and `n_oe` high, and drives `mem_doe` high with `mem_dout` equal to the write data.
- R7: A read in byte-write mode drives `n_oe` low and keeps all `n_we` lines and `n_wr` high.
- R8: A write in byte-select mode (`cfg_bsel`=1) drives `n_we[i]` low for the enabled lanes, drives `n_wr` low and keeps `n_oe` high.
- R9: A read in byte-select mode drives `n_oe` low and `n_we[i]` low for the enabled lanes, and keeps `n_wr` high.
- R10: In 16-bit mode (`cfg_wide`=0), `n_we[3:2]` stay high whatever `req_be` holds, and `rsp_rdata[31:16]` is zero.
- R11: In the cycle after the last active cycle, all strobes are high and `rsp_valid` is high for that one cycle only. `rsp_rdata` then carries `mem_din` as it stood on the last active cycle.
- R12: `req_ready` is low during every active cycle of an access.
- R13: A configuration write applies from the next accepted access onward. A write made while an access is running does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Chip select whose configuration is written |
| cfg_wide | input | 1 | 1 = 32-bit data, 0 = 16-bit data |
| cfg_bsel | input | 1 | 1 = byte-select mode, 0 = byte-write mode |
| cfg_wait | input | 4 | Wait-state count N |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address; top two bits pick the chip select |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| n_ce | output | 4 | Active-low chip enables |
| n_we | output | 4 | Active-low per-lane write strobes or lane selects |
| n_wr | output | 1 | Active-low shared write strobe (byte-select mode) |
| n_oe | output | 1 | Active-low output enable for reads |
| n_wait | input | 1 | Active-low external wait |
| mem_addr | output | 24 | External address |
| mem_dout | output | 32 | External write data |
| mem_doe | output | 1 | Drive enable for mem_dout |
| mem_din | input | 32 | External read data |

## Verification
The assertions assume that `n_wait` changes away from the rising clock edge and that it is not held low forever. The bench drives it low only on a counted number of active cycles, and it changes every input on the falling edge. The assertions also assume that configuration writes and requests never arrive together with reset. The directed tasks place each configuration write either before a request or inside a running access, and never in the cycle a request is taken. That keeps the rule for when a new configuration applies unambiguous.

// File: rtl/smc_pkg.sv
package smc_pkg;

  parameter int unsigned WS_W = 4;

  typedef struct packed {
    logic            wide;
    logic            bsel;
    logic [WS_W-1:0] wait_n;
  } smc_cfg_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } smc_state_e;

endpackage

// File: rtl/smc_cfg_bank.sv
module smc_cfg_bank
  import smc_pkg::*;
#(
  parameter int unsigned NCS       = 4,
  parameter bit          RST_WIDE  = 1'b0,
  localparam int unsigned CS_W     = $clog2(NCS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CS_W-1:0]     cfg_sel,
  input  smc_cfg_t            cfg_d,
  output smc_cfg_t            cfg_q [NCS]
);

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    // Select 0 is the boot device and always starts narrow.
    localparam bit RW = (c == 0) ? 1'b0 : RST_WIDE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[c] <= '{wide: RW, bsel: 1'b0, wait_n: '0};
      end else if (cfg_we && (cfg_sel == CS_W'(c))) begin
        cfg_q[c] <= cfg_d;
      end
    end
  end

endmodule

// File: rtl/smc_access_fsm.sv
module smc_access_fsm
  import smc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WS_W-1:0] ws,
  input  logic            n_wait,
  output logic            idle,
  output logic            active,
  output logic            last,
  output logic            done
);

  smc_state_e      state;
  logic [WS_W-1:0] cnt;

  assign idle   = (state == ST_IDLE);
  assign active = (state == ST_ACTIVE);
  // The final active cycle: no wait requested and no wait states left.
  assign last   = active && n_wait && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ACTIVE;
            cnt   <= ws;
          end
        end
        ST_ACTIVE: begin
          if (n_wait) begin
            if (cnt == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smc_strobe_map.sv
module smc_strobe_map
  import smc_pkg::*;
#(
  parameter int unsigned NCS   = 4,
  parameter int unsigned LANES = 4,
  localparam int unsigned CS_W = $clog2(NCS),
  localparam int unsigned HALF = LANES / 2
) (
  input  logic             active,
  input  logic [CS_W-1:0]  cs,
  input  logic             write,
  input  logic [LANES-1:0] be,
  input  smc_cfg_t         cfg,
  output logic [NCS-1:0]   n_ce,
  output logic [LANES-1:0] n_we,
  output logic             n_wr,
  output logic             n_oe,
  output logic             doe
);

  logic [LANES-1:0] lane_on;
  logic [LANES-1:0] eff_be;

  // Upper lanes exist only on a wide bus.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_low
      assign lane_on[i] = 1'b1;
    end else begin : g_high
      assign lane_on[i] = cfg.wide;
    end
  end

  assign eff_be = be & lane_on;

  always_comb begin
    n_ce = '1;
    if (active) n_ce[cs] = 1'b0;
  end

  // Lane strobes fire on writes in either mode, and on reads only as selects.
  assign n_we = (active && (write || cfg.bsel)) ? ~eff_be : '1;
  assign n_wr = ~(active && write && cfg.bsel);
  assign n_oe = ~(active && !write);
  assign doe  = active && write;

endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
  import smc_pkg::*;
#(
  parameter int unsigned NCS      = 4,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 32,
  parameter bit          RST_WIDE = 1'b0,
  localparam int unsigned CS_W    = $clog2(NCS),
  localparam int unsigned LANES   = DATA_W / 8,
  localparam int unsigned HALF    = LANES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic              cfg_wide,
  input  logic              cfg_bsel,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NCS-1:0]    n_ce,
  output logic [LANES-1:0]  n_we,
  output logic              n_wr,
  output logic              n_oe,
  input  logic              n_wait,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  smc_cfg_t          cfg_q [NCS];
  smc_cfg_t          cfg_d;
  smc_cfg_t          cur_cfg;
  logic [CS_W-1:0]   req_cs;
  logic [CS_W-1:0]   cur_cs;
  logic              cur_wr;
  logic [LANES-1:0]  cur_be;
  logic [DATA_W-1:0] cur_wdata;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] din_masked;
  logic              accept;
  logic              idle;
  logic              active;
  logic              last;

  assign cfg_d  = '{wide: cfg_wide, bsel: cfg_bsel, wait_n: cfg_wait};
  assign req_cs = req_addr[ADDR_W-1 -: CS_W];
  assign accept = req_valid && idle;
  assign req_ready = idle;

  smc_cfg_bank #(
    .NCS      (NCS),
    .RST_WIDE (RST_WIDE)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .cfg_d   (cfg_d),
    .cfg_q   (cfg_q)
  );

  // Snapshot of the request and its select's configuration, taken at accept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cfg   <= '0;
      cur_cs    <= '0;
      cur_wr    <= 1'b0;
      cur_be    <= '0;
      cur_wdata <= '0;
      cur_addr  <= '0;
    end else if (accept) begin
      cur_cfg   <= cfg_q[req_cs];
      cur_cs    <= req_cs;
      cur_wr    <= req_write;
      cur_be    <= req_be;
      cur_wdata <= req_wdata;
      cur_addr  <= req_addr;
    end
  end

  smc_access_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .ws     (cfg_q[req_cs].wait_n),
    .n_wait (n_wait),
    .idle   (idle),
    .active (active),
    .last   (last),
    .done   (rsp_valid)
  );

  smc_strobe_map #(
    .NCS   (NCS),
    .LANES (LANES)
  ) u_map (
    .active (active),
    .cs     (cur_cs),
    .write  (cur_wr),
    .be     (cur_be),
    .cfg    (cur_cfg),
    .n_ce   (n_ce),
    .n_we   (n_we),
    .n_wr   (n_wr),
    .n_oe   (n_oe),
    .doe    (mem_doe)
  );

  // Narrow bus: upper data lanes return zero.
  for (genvar i = 0; i < LANES; i++) begin : g_rd
    if (i < HALF) begin : g_low
      assign din_masked[8*i +: 8] = mem_din[8*i +: 8];
    end else begin : g_high
      assign din_masked[8*i +: 8] = cur_cfg.wide ? mem_din[8*i +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (last) begin
      rsp_rdata <= din_masked;
    end
  end

  assign mem_addr = cur_addr;
  assign mem_dout = cur_wdata;

endmodule

// File: rtl/smc_strobe_chk.sv
module smc_strobe_chk #(
  parameter int unsigned NCS   = 4,
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [NCS-1:0]   n_ce,
  input logic [LANES-1:0] n_we,
  input logic             n_wr,
  input logic             n_oe,
  input logic             n_wait,
  input logic             mem_doe
);

  a_r3_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~n_ce) <= 1);

  a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (&n_ce));

  a_r11_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((&n_ce) && n_oe && n_wr && (&n_we) && !mem_doe));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&n_ce) |-> rsp_valid);

  a_r5_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_wait && !(&n_ce)) |=> (!(&n_ce) && $stable(n_ce)));

  a_r7_oe_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !n_oe |-> (n_wr && !mem_doe));

  a_r6_doe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !(&n_ce));

endmodule

bind smc_strobe_gen smc_strobe_chk #(
  .NCS   (NCS),
  .LANES (LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .n_ce      (n_ce),
  .n_we      (n_we),
  .n_wr      (n_wr),
  .n_oe      (n_oe),
  .n_wait    (n_wait),
  .mem_doe   (mem_doe)
);

// File: tb/smc_strobe_gen_test.sv
`timescale 1ns/1ps
module smc_strobe_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_wide = 1'b0;
  logic        cfg_bsel = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  n_ce;
  logic [3:0]  n_we;
  logic        n_wr;
  logic        n_oe;
  logic        n_wait = 1'b1;
  logic [23:0] mem_addr;
  logic [31:0] mem_dout;
  logic        mem_doe;
  logic [31:0] mem_din = '0;

  int checks = 0;
  int errors = 0;

  // Observations of the most recent access.
  int          obs_len;
  logic [3:0]  obs_ce, obs_we;
  logic        obs_wr, obs_oe, obs_doe, obs_ready_ok, obs_rsp, obs_rsp_after;
  logic [31:0] obs_dout, obs_rdata;
  logic [23:0] obs_addr;

  always #2 clk = ~clk;

  smc_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wide(cfg_wide), .cfg_bsel(cfg_bsel), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .n_ce(n_ce), .n_we(n_we),
    .n_wr(n_wr), .n_oe(n_oe), .n_wait(n_wait), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic wide,
                           input logic bsel, input logic [3:0] ws);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wide = wide; cfg_bsel = bsel; cfg_wait = ws;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_access(input logic [1:0] cs, input logic wr,
                            input logic [3:0] be, input logic [31:0] wd,
                            input logic [31:0] din, input int lows,
                            input bit mid_cfg, input logic [3:0] mid_ws);
    int left = lows;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_wdata = wd;
    req_addr = {cs, 22'h2A5A5}; mem_din = din; n_wait = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    obs_len = 0; obs_ready_ok = 1'b1;
    for (int g = 0; g < 100; g++) begin
      if (&n_ce) break;
      if (obs_len == 0) begin
        obs_ce = n_ce; obs_we = n_we; obs_wr = n_wr; obs_oe = n_oe;
        obs_doe = mem_doe; obs_dout = mem_dout; obs_addr = mem_addr;
      end
      if (req_ready) obs_ready_ok = 1'b0;
      obs_len++;
      if (mid_cfg && obs_len == 1) begin
        cfg_we = 1'b1; cfg_sel = cs; cfg_wide = 1'b1; cfg_bsel = 1'b0; cfg_wait = mid_ws;
      end else begin
        cfg_we = 1'b0;
      end
      if (left > 0) begin n_wait = 1'b0; left--; end
      else n_wait = 1'b1;
      @(negedge clk);
    end
    n_wait = 1'b1; cfg_we = 1'b0;
    obs_rsp = rsp_valid; obs_rdata = rsp_rdata;
    check((&n_ce) && n_oe && n_wr && (&n_we), "R11 strobes high after end",
          {n_ce, n_we, 22'd0, n_wr, n_oe}, {4'hF, 4'hF, 22'd0, 2'b11});
    @(negedge clk);
    obs_rsp_after = rsp_valid;
  endtask

  task automatic t_reset;
    check(n_ce == 4'hF && n_we == 4'hF && n_wr && n_oe, "R1 strobes idle",
          {n_ce, n_we, n_wr, n_oe}, {4'hF, 4'hF, 2'b11});
    check(!mem_doe && !rsp_valid && req_ready, "R1 handshake idle",
          {mem_doe, rsp_valid, req_ready}, 3'b001);
  endtask

  task automatic t_boot_cs0;
    run_access(2'd0, 1'b0, 4'hF, 32'h0, 32'hA5A5_1234, 0, 1'b0, 4'd0);
    check(obs_rdata == 32'h0000_1234, "R2 R10 cs0 narrow read", obs_rdata, 32'h0000_1234);
    check(obs_len == 1, "R2 R4 zero wait after reset", obs_len, 1);
    check(obs_we == 4'hF && !obs_oe && obs_wr, "R7 byte-write read strobes",
          {obs_we, obs_wr, obs_oe}, {4'hF, 2'b10});
    check(obs_ce == 4'b1110, "R3 cs0 enable", obs_ce, 4'b1110);
    check(obs_rsp && !obs_rsp_after, "R11 one-cycle done", {obs_rsp, obs_rsp_after}, 2'b10);
  endtask

  task automatic t_bytewrite_write;
    cfg_write(2'd1, 1'b1, 1'b0, 4'd2);
    run_access(2'd1, 1'b1, 4'b0101, 32'hDEAD_BEEF, 32'h0, 0, 1'b0, 4'd0);
    check(obs_we == 4'b1010, "R6 lane write strobes", obs_we, 4'b1010);
    check(obs_wr && obs_oe && obs_doe, "R6 wr/oe high, drive on",
          {obs_wr, obs_oe, obs_doe}, 3'b111);
    check(obs_dout == 32'hDEAD_BEEF, "R6 write data", obs_dout, 32'hDEAD_BEEF);
    check(obs_len == 3, "R4 1+N cycles", obs_len, 3);
    check(obs_ce == 4'b1101, "R3 cs1 enable", obs_ce, 4'b1101);
    check(obs_addr == {2'd1, 22'h2A5A5}, "R3 address out", obs_addr, {2'd1, 22'h2A5A5});
    check(obs_ready_ok, "R12 ready low while active", obs_ready_ok, 1);
  endtask

  task automatic t_byteselect;
    cfg_write(2'd2, 1'b1, 1'b1, 4'd0);
    run_access(2'd2, 1'b1, 4'b0011, 32'h1111_2222, 32'h0, 0, 1'b0, 4'd0);
    check(obs_we == 4'b1100 && !obs_wr && obs_oe, "R8 byte-select write",
          {obs_we, obs_wr, obs_oe}, {4'b1100, 2'b01});
    check(obs_ce == 4'b1011, "R3 cs2 enable", obs_ce, 4'b1011);
    run_access(2'd2, 1'b0, 4'b1000, 32'h0, 32'hCAFE_F00D, 0, 1'b0, 4'd0);
    check(obs_we == 4'b0111 && obs_wr && !obs_oe, "R9 byte-select read",
          {obs_we, obs_wr, obs_oe}, {4'b0111, 2'b10});
    check(obs_rdata == 32'hCAFE_F00D, "R11 wide read data", obs_rdata, 32'hCAFE_F00D);
  endtask

  task automatic t_narrow;
    cfg_write(2'd3, 1'b0, 1'b1, 4'd1);
    run_access(2'd3, 1'b1, 4'hF, 32'h5555_AAAA, 32'h0, 0, 1'b0, 4'd0);
    check(obs_we == 4'b1100, "R10 upper lanes idle on write", obs_we, 4'b1100);
    check(obs_len == 2, "R4 N=1", obs_len, 2);
    run_access(2'd3, 1'b0, 4'hF, 32'h0, 32'h9876_5432, 0, 1'b0, 4'd0);
    check(obs_we == 4'b1100 && obs_rdata == 32'h0000_5432, "R10 narrow select read",
          {obs_we, obs_rdata[27:0]}, {4'b1100, 28'h0005432});
  endtask

  task automatic t_wait;
    run_access(2'd1, 1'b0, 4'hF, 32'h0, 32'h0BAD_CAFE, 3, 1'b0, 4'd0);
    check(obs_len == 6, "R5 three wait cycles add", obs_len, 6);
    check(obs_rdata == 32'h0BAD_CAFE, "R11 data after wait", obs_rdata, 32'h0BAD_CAFE);
    check(obs_ready_ok, "R12 ready low during wait", obs_ready_ok, 1);
  endtask

  task automatic t_live_cfg;
    cfg_write(2'd1, 1'b1, 1'b0, 4'd3);
    run_access(2'd1, 1'b0, 4'hF, 32'h0, 32'h0, 0, 1'b1, 4'd0);
    check(obs_len == 4, "R13 running access unchanged", obs_len, 4);
    run_access(2'd1, 1'b0, 4'hF, 32'h0, 32'h0, 0, 1'b0, 4'd0);
    check(obs_len == 1, "R13 next access uses new count", obs_len, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_boot_cs0;
    t_bytewrite_write;
    t_byteselect;
    t_narrow;
    t_wait;
    t_live_cfg;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule